// File: doc/BRIEF.md
# Disc Interface Status Readout

This block answers the host's "load status into accumulator" instruction for a disc interface. While an instruction runs, the host puts a device select code on its I/O lines and pulses a T2 phase strobe. The block registers whether the code matches its own select code, and that result holds until the next T2. When the host then asserts its I/O gate and its input enable together, the block drives its status word onto a 16-bit input bus. The host captures the bus into its accumulator late in the instruction, at T5. In every other cycle the block drives all zeros, so several devices can share the bus through a plain OR.

The status word reports four things. The first is the read parity error flag. The second is an abort flag, which the block keeps itself. The third is a busy indication. The fourth is the sector counter value, which gives the next-sector address. The abort flag is set when the drive reports not-ready or when the interface clear is asserted. It stays set until a new operation is started, so the host can still read it after the operation has ended. The sector counter advances on its own, out of step with the host. To stop the count from changing while the host reads it, the block samples the count into a snapshot register and freezes that register while the readout is gated.

Top module: `status_readout`

## Requirements
- R1: After reset, the abort flag and the select latch are clear and the bus reads all zeros.
- R2: At each rising clock edge where t2_i is high, the select latch loads whether sel_code_i equals DEV_SEL (default 6'o23). It holds its value at all other edges.
- R3: bus_o is all zeros unless the select latch, io_gate_i and io_in_i are all high. This holds for every combination of the three.
- R4: While the bus is driven, bit 0 equals parity_err_i.
- R5: While the bus is driven, bit 1 shows the abort flag. The flag is set at a clock edge where drive_ready_i is low.
- R6: The abort flag is also set at a clock edge where clear_i is high.
- R7: At an edge where neither set condition holds, start_i clears the abort flag. Either set condition wins over start_i. With no set condition and no start_i, the flag holds its value.
- R8: While the bus is driven, bits 7:3 show the sector snapshot. The snapshot loads sector_i at every edge where the select latch and io_gate_i are not both high, and it is frozen while both are high.
- R9: While the bus is driven, bit 2 equals busy_i and bits 15:8 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_code_i | input | 6 | Device select code from the host |
| t2_i | input | 1 | T2 phase strobe; the select decode is latched at this phase |
| io_gate_i | input | 1 | Host I/O gate for the current instruction |
| io_in_i | input | 1 | Host input-direction enable |
| start_i | input | 1 | New disc operation start; clears the abort flag |
| drive_ready_i | input | 1 | Drive ready; low sets the abort flag |
| clear_i | input | 1 | Interface clear; high sets the abort flag |
| parity_err_i | input | 1 | Read parity error flag |
| busy_i | input | 1 | Operation in progress |
| sector_i | input | 5 | Free-running sector counter value |
| bus_o | output | 16 | Input bus to the host, all zeros when not gated |

## Verification
The bus gate is combinational. The bench therefore checks gating, parity and busy in the same half-cycle as the input change, one time unit after it drives inputs on the falling edge. The select latch, the abort flag and the sector snapshot are each one register deep. Their effects become visible only after the next rising edge, so the bench makes one rising edge pass and checks at the following falling edge. The sector checks change sector_i after the gate opens, which confirms that the value read is the one captured at the last edge before the freeze. The value read stays unchanged across a further edge.

// File: rtl/status_readout_pkg.sv
package status_readout_pkg;
  localparam int unsigned BUS_W     = 16;
  localparam int unsigned SEL_W     = 6;
  localparam int unsigned SECT_W    = 5;
  localparam int unsigned PAR_BIT   = 0;
  localparam int unsigned ABORT_BIT = 1;
  localparam int unsigned BUSY_BIT  = 2;
  localparam int unsigned SECT_LSB  = 3;
  localparam int unsigned SECT_MSB  = SECT_LSB + SECT_W - 1;

  typedef struct packed {
    logic [SECT_W-1:0] sector;
    logic              busy;
    logic              abort;
    logic              parity;
  } status_t;

  localparam int unsigned STAT_W = $bits(status_t);
endpackage

// File: rtl/sel_latch.sv
module sel_latch #(
  parameter int unsigned SEL_W = 6,
  parameter logic [SEL_W-1:0] DEV_SEL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_code_i,
  input  logic             t2_i,
  output logic             sel_o
);
  logic match;
  assign match = (sel_code_i == DEV_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= 1'b0;
    else if (t2_i) sel_o <= match;
  end
endmodule

// File: rtl/abort_tracker.sv
module abort_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_ready_i,
  input  logic clear_i,
  input  logic start_i,
  output logic abort_o
);
  logic set_cond;
  assign set_cond = !drive_ready_i || clear_i;

  // set dominates start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       abort_o <= 1'b0;
    else if (set_cond) abort_o <= 1'b1;
    else if (start_i)  abort_o <= 1'b0;
  end
endmodule

// File: rtl/sector_snap.sv
module sector_snap #(
  parameter int unsigned SECT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic [SECT_W-1:0] snap_o
);
  // avoids reading a count mid-ripple while the host samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_o <= '0;
    else if (!freeze_i) snap_o <= sector_i;
  end
endmodule

// File: rtl/bus_gate.sv
module bus_gate #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned STAT_W = 8
) (
  input  logic              en_i,
  input  logic [STAT_W-1:0] word_i,
  output logic [BUS_W-1:0]  bus_o
);
  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    if (i < STAT_W) begin : g_live
      assign bus_o[i] = en_i & word_i[i];
    end else begin : g_zero
      assign bus_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/status_readout.sv
module status_readout
  import status_readout_pkg::*;
#(
  parameter logic [SEL_W-1:0] DEV_SEL = 6'o23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_code_i,
  input  logic              t2_i,
  input  logic              io_gate_i,
  input  logic              io_in_i,
  input  logic              start_i,
  input  logic              drive_ready_i,
  input  logic              clear_i,
  input  logic              parity_err_i,
  input  logic              busy_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic [BUS_W-1:0]  bus_o
);
  logic              sel_q;
  logic              abort_q;
  logic [SECT_W-1:0] snap_q;
  logic              freeze;
  logic              bus_en;
  status_t           word;

  sel_latch #(.SEL_W(SEL_W), .DEV_SEL(DEV_SEL)) i_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_code_i (sel_code_i),
    .t2_i       (t2_i),
    .sel_o      (sel_q)
  );

  abort_tracker i_abort (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .drive_ready_i (drive_ready_i),
    .clear_i       (clear_i),
    .start_i       (start_i),
    .abort_o       (abort_q)
  );

  assign freeze = sel_q & io_gate_i;

  sector_snap #(.SECT_W(SECT_W)) i_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .freeze_i (freeze),
    .sector_i (sector_i),
    .snap_o   (snap_q)
  );

  assign bus_en = freeze & io_in_i;

  always_comb begin
    word        = '0;
    word.parity = parity_err_i;
    word.abort  = abort_q;
    word.busy   = busy_i;
    word.sector = snap_q;
  end

  bus_gate #(.BUS_W(BUS_W), .STAT_W(STAT_W)) i_gate (
    .en_i   (bus_en),
    .word_i (word),
    .bus_o  (bus_o)
  );
endmodule

// File: rtl/status_readout_chk.sv
module status_readout_chk
  import status_readout_pkg::*;
#(
  parameter logic [SEL_W-1:0] DEV_SEL = 6'o23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  sel_code_i,
  input logic              t2_i,
  input logic              io_gate_i,
  input logic              io_in_i,
  input logic              start_i,
  input logic              drive_ready_i,
  input logic              clear_i,
  input logic              parity_err_i,
  input logic              sel_q,
  input logic              abort_q,
  input logic [SECT_W-1:0] snap_q,
  input logic [BUS_W-1:0]  bus_o
);
  AST_BUS_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_q && io_gate_i && io_in_i) |-> bus_o == '0); // R3

  AST_SEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t2_i |=> sel_q == $past(sel_code_i == DEV_SEL)); // R2

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t2_i |=> $stable(sel_q)); // R2

  AST_PARITY_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && io_gate_i && io_in_i) |-> bus_o[PAR_BIT] == parity_err_i); // R4

  AST_ABORT_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_ready_i |=> abort_q); // R5

  AST_ABORT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> abort_q); // R6

  AST_ABORT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && drive_ready_i && !clear_i) |=> !abort_q); // R7

  AST_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && drive_ready_i && !clear_i) |=> $stable(abort_q)); // R7

  AST_SNAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && io_gate_i) |=> $stable(snap_q)); // R8
endmodule

bind status_readout status_readout_chk #(.DEV_SEL(DEV_SEL)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_code_i    (sel_code_i),
  .t2_i          (t2_i),
  .io_gate_i     (io_gate_i),
  .io_in_i       (io_in_i),
  .start_i       (start_i),
  .drive_ready_i (drive_ready_i),
  .clear_i       (clear_i),
  .parity_err_i  (parity_err_i),
  .sel_q         (sel_q),
  .abort_q       (abort_q),
  .snap_q        (snap_q),
  .bus_o         (bus_o)
);

// File: tb/test_status_readout.sv
`timescale 1ns/1ps
module test_status_readout;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] DEV = 6'o23;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  sel_code_i = '0;
  logic        t2_i = 0, io_gate_i = 0, io_in_i = 0, start_i = 0;
  logic        drive_ready_i = 1, clear_i = 0, parity_err_i = 0, busy_i = 0;
  logic [4:0]  sector_i = '0;
  logic [15:0] bus_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  status_readout i_status_readout (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic select(input logic [5:0] code);
    t2_i = 1; sel_code_i = code;
    step();
    t2_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    io_gate_i = 1; io_in_i = 1; busy_i = 1;
    #(CLK_PERIOD*2 + 1);
    check("R1", bus_o, 16'h0);
    @(negedge clk_i); rst_ni = 1;
    step(); #1;
    check("R1", bus_o, 16'h0);
    io_gate_i = 0; io_in_i = 0; busy_i = 0;

    // R2 select sweep over all codes
    for (int c = 0; c < 64; c++) begin
      select(6'(c));
      busy_i = 1; io_gate_i = 1; io_in_i = 1; sel_code_i = DEV; #1;
      check("R2", bus_o, (6'(c) == DEV) ? 16'h0004 : 16'h0);
      step(); #1;
      check("R2", bus_o, (6'(c) == DEV) ? 16'h0004 : 16'h0);
      io_gate_i = 0; io_in_i = 0; step();
    end

    // R3 all gating combinations, selected and not
    for (int s = 0; s < 2; s++) begin
      select(s[0] ? DEV : ~DEV);
      for (int g = 0; g < 4; g++) begin
        io_gate_i = g[0]; io_in_i = g[1]; busy_i = 1; #1;
        check("R3", bus_o, (s[0] && g == 3) ? 16'h0004 : 16'h0);
        io_gate_i = 0; io_in_i = 0; step();
      end
    end

    // R4, R9 parity/busy patterns
    select(DEV);
    for (int p = 0; p < 4; p++) begin
      parity_err_i = p[0]; busy_i = p[1]; io_gate_i = 1; io_in_i = 1; #1;
      check("R4", {15'h0, bus_o[0]}, {15'h0, p[0]});
      check("R9", {8'h0, bus_o[15:8]}, 16'h0);
      check("R9", {15'h0, bus_o[2]}, {15'h0, p[1]});
      io_gate_i = 0; io_in_i = 0; step();
    end
    parity_err_i = 0; busy_i = 0;

    // R5 R6 R7 abort sweep: prior state x ready x clear x start
    io_gate_i = 1; io_in_i = 1;
    for (int k = 0; k < 16; k++) begin
      logic prior, nxt;
      prior = k[3];
      if (prior) drive_ready_i = 0; else start_i = 1;
      step();
      drive_ready_i = 1; start_i = 0; #1;
      check("R7", {15'h0, bus_o[1]}, {15'h0, prior});
      drive_ready_i = k[0]; clear_i = k[1]; start_i = k[2];
      nxt = (!k[0] || k[1]) ? 1'b1 : (k[2] ? 1'b0 : prior);
      step();
      drive_ready_i = 1; clear_i = 0; start_i = 0; #1;
      check(!k[0] ? "R5" : (k[1] ? "R6" : "R7"), {15'h0, bus_o[1]}, {15'h0, nxt});
    end
    io_gate_i = 0; io_in_i = 0;

    // R8 sector snapshot: value at last edge before freeze, held across edges
    for (int v = 0; v < 32; v++) begin
      sector_i = 5'(v);
      step();
      io_gate_i = 1; io_in_i = 1; sector_i = ~5'(v); #1;
      check("R8", {11'h0, bus_o[7:3]}, 16'(v));
      step(); #1;
      check("R8", {11'h0, bus_o[7:3]}, 16'(v));
      io_gate_i = 0; io_in_i = 0;
    end
    // after gate drops snapshot follows again
    sector_i = 5'd9; step();
    io_gate_i = 1; io_in_i = 1; #1;
    check("R8", {11'h0, bus_o[7:3]}, 16'd9);
    io_gate_i = 0; io_in_i = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule